// File: doc/BRIEF.md
# Ring Aggregation Node

This block is one station on a one-way chain of processing chips that carries results back to a collecting master. Each station receives a 4-bit nibble stream from its upstream neighbour, qualified by a valid strobe. It sends an identical nibble stream with its own strobe to the next station. Every packet that enters is copied out unchanged and in its arrival order.

There is no arbiter and no token field. A station knows its turn has come when it has finished copying out the packet whose source identifier belongs to the station just before it. It then sends exactly one packet of its own. That packet carries real words from a local queue if the queue had any words when the turn began. Otherwise it is a null packet that says the station had nothing to contribute. The master opens each round with an empty packet that uses the reserved identifier 0x3F, and station 0 takes that packet as its predecessor's packet.

While the station is sending its own packet, upstream traffic keeps arriving. That traffic is held in an internal buffer and released afterwards.

Top module: `ring_agg_node`

## Requirements
- R1: While `rst` is high, `dn_en` and `loc_pop` stay low. The first clock edge after `rst` falls also leaves `dn_en` low, and no turn is pending.
- R2: Every upstream packet is forwarded nibble for nibble, with no change and in arrival order. When the output side is idle and no turn is pending, a nibble presented before clock edge k appears on `dn_dat` after edge k+2.
- R3: Packet layout, one nibble per enabled cycle, with the strobe high for the whole packet. The first nibble is source ID bits [5:2]. The second nibble is {ID[1:0], type, 0}, where type 1 means data and type 0 means null. The third nibble is the payload length in 16-bit words. The payload follows, four nibbles per word, most significant nibble first.
- R4: The station's own packet starts one idle cycle after it finishes forwarding a packet whose source ID equals NODE_ID-1. For NODE_ID 0, that source ID is 0x3F.
- R5: If `loc_len` is 0 when the turn begins, the station sends a null packet: type 0, length 0, three nibbles.
- R6: `loc_len` (saturated to 15 by the source) is latched at the start of the turn. Exactly that many words are sent, with one `loc_pop` per word, taken while its first nibble leaves. Words that arrive later wait for a later turn.
- R7: Upstream packets that arrive while the station's own packet is being sent are buffered without loss and are forwarded after it, in order.
- R8: The strobe goes low for at least one cycle after the last nibble of every outgoing packet.
- R9: A forwarded packet from any source other than the predecessor does not start a turn.
- R10: If `up_en` is already high when reset is released, that packet fragment is discarded. Reception resumes only after `up_en` has been low for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_en | input | 1 | Upstream strobe, high across a packet |
| up_dat | input | 4 | Upstream nibble |
| dn_en | output | 1 | Downstream strobe |
| dn_dat | output | 4 | Downstream nibble |
| loc_len | input | 4 | Words ready in the local queue, saturated at 15 |
| loc_word | input | 16 | Head word of the local queue |
| loc_pop | output | 1 | Removes the head word at this clock edge |

## Verification
The assertions assume well-formed upstream traffic. Every packet's length matches its length nibble, the strobe falls for at least a cycle between packets, and upstream packets never arrive back to back for longer than the buffer can absorb during one own packet. They also assume that the local queue keeps `loc_word` valid for as long as `loc_len` promised. The stimulus builds every upstream packet from its length field and adds one idle cycle after each. It sends the longest legal packet directly behind the predecessor's packet to fill the buffer. It only removes local words on `loc_pop`, and it only adds them at the tail.

// File: rtl/ring_node_pkg.sv
`timescale 1ns/1ps
package ring_node_pkg;
  localparam int NIB_W = 4;
  localparam int ID_W  = 6;
  localparam logic [ID_W-1:0] START_ID = 6'h3F;

  typedef enum logic [1:0] {TX_IDLE, TX_FWD, TX_OWN, TX_GAP} tx_state_t;

  // Source ID whose packet hands the turn to station `id`.
  function automatic logic [ID_W-1:0] pred_of(input int unsigned id);
    return (id == 0) ? START_ID : ID_W'(id - 1);
  endfunction
endpackage

// File: rtl/ring_rx_buffer.sv
`timescale 1ns/1ps
module ring_rx_buffer
  import ring_node_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic [NIB_W-1:0] in_dat,
  input  logic             rd,
  output logic [NIB_W-1:0] rd_dat,
  output logic             rd_last,
  output logic             empty,
  output logic             full,
  output logic             wr
);
  localparam int AW = $clog2(DEPTH);

  logic             armed;
  logic             cap_en;
  logic [NIB_W-1:0] cap_dat;
  logic [AW:0]      wp, rp;
  logic [NIB_W:0]   mem [DEPTH];

  assign wr = cap_en;

  // One capture stage so the end of a packet is known when its last nibble is stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cap_en  <= 1'b0;
      cap_dat <= '0;
      wp      <= '0;
      rp      <= '0;
    end else begin
      armed   <= armed | ~in_en;
      cap_en  <= in_en & armed;
      cap_dat <= in_dat;
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= {~in_en, cap_dat};
  end

  assign {rd_last, rd_dat} = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/ring_turn_detect.sv
`timescale 1ns/1ps
module ring_turn_detect
  import ring_node_pkg::*;
#(
  parameter int NODE_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic [NIB_W-1:0] pop_dat,
  input  logic             pop_last,
  input  logic             own_start,
  output logic             turn_pending
);
  localparam logic [ID_W-1:0] PRED_ID = pred_of(NODE_ID);
  localparam int LO_W = ID_W - NIB_W;

  logic [1:0]       pos;
  logic [NIB_W-1:0] id_hi;
  logic [LO_W-1:0]  id_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos          <= '0;
      id_hi        <= '0;
      id_lo        <= '0;
      turn_pending <= 1'b0;
    end else begin
      if (own_start) turn_pending <= 1'b0;
      if (pop) begin
        if (pos == 2'd0) id_hi <= pop_dat;
        if (pos == 2'd1) id_lo <= pop_dat[NIB_W-1 -: LO_W];
        if (pop_last) begin
          pos <= '0;
          if ({id_hi, id_lo} == PRED_ID) turn_pending <= 1'b1;
        end else if (pos != 2'd2) begin
          pos <= pos + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ring_tx_engine.sv
`timescale 1ns/1ps
module ring_tx_engine
  import ring_node_pkg::*;
#(
  parameter int NODE_ID = 0,
  parameter int LEN_W   = 4,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              turn_pending,
  input  logic              buf_empty,
  input  logic [NIB_W-1:0]  buf_dat,
  input  logic              buf_last,
  output logic              buf_rd,
  output logic              own_start,
  input  logic [LEN_W-1:0]  loc_len,
  input  logic [WORD_W-1:0] loc_word,
  output logic              loc_pop,
  output logic              out_en,
  output logic [NIB_W-1:0]  out_dat,
  output logic              out_last
);
  localparam int NPW   = WORD_W / NIB_W;
  localparam int POS_W = (NPW > 1) ? $clog2(NPW) : 1;
  localparam int IDX_W = $clog2(3 + NPW * ((1 << LEN_W) - 1) + 1);
  localparam int SH_W  = WORD_W - NIB_W;
  localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

  tx_state_t        state;
  logic [IDX_W-1:0] idx, last_idx;
  logic [LEN_W-1:0] len_q;
  logic [POS_W-1:0] pos;
  logic [SH_W-1:0]  sh;
  logic             payload;
  logic [NIB_W-1:0] own_nib;

  assign payload   = idx > IDX_W'(2);
  assign own_start = (state == TX_IDLE) && turn_pending;
  assign buf_rd    = (state == TX_FWD) ||
                     ((state == TX_IDLE) && !turn_pending && !buf_empty);
  assign loc_pop   = (state == TX_OWN) && payload && (pos == '0);

  always_comb begin
    if (idx == IDX_W'(1))      own_nib = {MY_ID[ID_W-NIB_W-1:0], |len_q, 1'b0};
    else if (idx == IDX_W'(2)) own_nib = NIB_W'(len_q);
    else if (pos == '0)        own_nib = loc_word[WORD_W-1 -: NIB_W];
    else                       own_nib = sh[SH_W-1 -: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      out_en   <= 1'b0;
      out_dat  <= '0;
      out_last <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      len_q    <= '0;
      pos      <= '0;
      sh       <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (turn_pending) begin
            out_en   <= 1'b1;
            out_dat  <= MY_ID[ID_W-1 -: NIB_W];
            out_last <= 1'b0;
            len_q    <= loc_len;
            last_idx <= IDX_W'(2) + IDX_W'(NPW) * IDX_W'(loc_len);
            idx      <= IDX_W'(1);
            pos      <= '0;
            state    <= TX_OWN;
          end else if (!buf_empty) begin
            out_en   <= 1'b1;
            out_dat  <= buf_dat;
            out_last <= buf_last;
            state    <= buf_last ? TX_GAP : TX_FWD;
          end else begin
            out_en   <= 1'b0;
            out_last <= 1'b0;
          end
        end
        TX_FWD: begin
          out_en   <= 1'b1;
          out_dat  <= buf_dat;
          out_last <= buf_last;
          if (buf_last) state <= TX_GAP;
        end
        TX_OWN: begin
          out_en   <= 1'b1;
          out_dat  <= own_nib;
          out_last <= (idx == last_idx);
          idx      <= idx + 1'b1;
          if (payload) begin
            pos <= (pos == POS_W'(NPW - 1)) ? '0 : pos + 1'b1;
            sh  <= (pos == '0) ? loc_word[SH_W-1:0] : (sh << NIB_W);
          end
          if (idx == last_idx) state <= TX_GAP;
        end
        default: begin
          out_en   <= 1'b0;
          out_last <= 1'b0;
          state    <= TX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ring_agg_node.sv
`timescale 1ns/1ps
module ring_agg_node
  import ring_node_pkg::*;
#(
  parameter int NODE_ID   = 0,
  parameter int LEN_W     = 4,
  parameter int WORD_W    = 16,
  parameter int BUF_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_en,
  input  logic [NIB_W-1:0]  up_dat,
  output logic              dn_en,
  output logic [NIB_W-1:0]  dn_dat,
  input  logic [LEN_W-1:0]  loc_len,
  input  logic [WORD_W-1:0] loc_word,
  output logic              loc_pop
);
  logic             buf_rd, buf_wr, buf_empty, buf_full, buf_last;
  logic [NIB_W-1:0] buf_dat;
  logic             turn_pending, own_start, tx_last;

  ring_rx_buffer #(.DEPTH(BUF_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .in_en(up_en), .in_dat(up_dat),
    .rd(buf_rd), .rd_dat(buf_dat), .rd_last(buf_last),
    .empty(buf_empty), .full(buf_full), .wr(buf_wr)
  );

  ring_turn_detect #(.NODE_ID(NODE_ID)) u_turn (
    .clk(clk), .rst(rst), .pop(buf_rd), .pop_dat(buf_dat),
    .pop_last(buf_last), .own_start(own_start), .turn_pending(turn_pending)
  );

  ring_tx_engine #(.NODE_ID(NODE_ID), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .turn_pending(turn_pending),
    .buf_empty(buf_empty), .buf_dat(buf_dat), .buf_last(buf_last),
    .buf_rd(buf_rd), .own_start(own_start),
    .loc_len(loc_len), .loc_word(loc_word), .loc_pop(loc_pop),
    .out_en(dn_en), .out_dat(dn_dat), .out_last(tx_last)
  );
endmodule

// File: rtl/ring_agg_node_checker.sv
`timescale 1ns/1ps
module ring_agg_node_checker (
  input logic clk,
  input logic rst,
  input logic dn_en,
  input logic tx_last,
  input logic buf_wr,
  input logic buf_full,
  input logic buf_rd,
  input logic buf_empty,
  input logic loc_pop,
  input logic own_start,
  input logic turn_pending
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk) rst |=> !dn_en);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    buf_wr |-> !buf_full);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    buf_rd |-> !buf_empty);

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !dn_en);

  assert_pop_emits_R6: assert property (@(posedge clk) disable iff (rst)
    loc_pop |=> dn_en);

  assert_turn_consumed_R4: assert property (@(posedge clk) disable iff (rst)
    own_start |=> !turn_pending);
endmodule

bind ring_agg_node ring_agg_node_checker u_chk (
  .clk(clk), .rst(rst), .dn_en(dn_en), .tx_last(tx_last),
  .buf_wr(buf_wr), .buf_full(buf_full), .buf_rd(buf_rd),
  .buf_empty(buf_empty), .loc_pop(loc_pop), .own_start(own_start),
  .turn_pending(turn_pending)
);

// File: tb/ring_agg_node_test.sv
`timescale 1ns/1ps
module ring_agg_node_test;
  localparam int NODE_ID = 2;
  localparam int PRED    = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_en = 1'b0;
  logic [3:0]  up_dat = '0;
  logic [3:0]  loc_len = '0;
  logic [15:0] loc_word = '0;
  wire         dn_en;
  wire  [3:0]  dn_dat;
  wire         loc_pop;

  always #5 clk = ~clk;

  ring_agg_node #(.NODE_ID(NODE_ID), .LEN_W(4), .WORD_W(16), .BUF_DEPTH(128)) uut (
    .clk(clk), .rst(rst), .up_en(up_en), .up_dat(up_dat),
    .dn_en(dn_en), .dn_dat(dn_dat), .loc_len(loc_len),
    .loc_word(loc_word), .loc_pop(loc_pop)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  int sq_en[$];
  int sq_dat[$];
  int lq[$];

  typedef struct { int nib; bit last; int ready; } ent_t;
  ent_t  fq[$];
  int    m_state = 0;
  bit    m_turn = 0, m_armed = 0, m_cap_v = 0;
  int    m_cap_n = 0, m_pos = 0, m_id = 0;
  int    own_list[$];
  bit    exp_en = 0;
  int    exp_dat = 0;
  string exp_tag = "R1";
  bit    pop_d = 0;

  int rec_id[$], rec_type[$], rec_len[$];
  int cur[$];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int word_val(int id, int w);
    return (id * 16'h1111 + w * 16'h0305 + 16'h0a5c) & 16'hffff;
  endfunction

  task automatic put_pkt(int id, int typ, int words);
    sq_en.push_back(1); sq_dat.push_back((id >> 2) & 15);
    sq_en.push_back(1); sq_dat.push_back(((id & 3) << 2) | (typ << 1));
    sq_en.push_back(1); sq_dat.push_back(words);
    for (int w = 0; w < words; w++) begin
      for (int k = 3; k >= 0; k--) begin
        sq_en.push_back(1); sq_dat.push_back((word_val(id, w) >> (4 * k)) & 15);
      end
    end
    sq_en.push_back(0); sq_dat.push_back(0);
  endtask

  task automatic fwd_one();
    ent_t e;
    if (fq.size() == 0) begin exp_en = 0; exp_tag = "R2"; return; end
    e = fq.pop_front();
    exp_en = 1; exp_dat = e.nib; exp_tag = "R2";
    if (m_pos == 0) m_id = e.nib << 2;
    else if (m_pos == 1) m_id = m_id | (e.nib >> 2);
    m_pos++;
    if (e.last) begin
      m_pos = 0;
      if (m_id == PRED) m_turn = 1;
      m_state = 3;
    end else m_state = 1;
  endtask

  task automatic model_step();
    int n;
    if (rst) begin
      fq.delete(); own_list.delete();
      m_state = 0; m_turn = 0; m_armed = 0; m_cap_v = 0; m_pos = 0; m_id = 0;
      exp_en = 0; exp_tag = "R1";
      return;
    end
    case (m_state)
      0: begin
        if (m_turn) begin
          n = loc_len;
          own_list.push_back(NODE_ID >> 2);
          own_list.push_back(((NODE_ID & 3) << 2) | ((n != 0) ? 2 : 0));
          own_list.push_back(n);
          for (int w = 0; w < n; w++)
            for (int k = 3; k >= 0; k--) own_list.push_back((lq[w] >> (4 * k)) & 15);
          m_turn = 0;
          exp_en = 1; exp_dat = own_list.pop_front(); exp_tag = "R4";
          m_state = 2;
        end else if (fq.size() > 0 && fq[0].ready <= cyc) begin
          fwd_one();
        end else begin
          exp_en = 0; exp_tag = "R9";
        end
      end
      1: fwd_one();
      2: begin
        exp_en = 1; exp_dat = own_list.pop_front(); exp_tag = "R3";
        if (own_list.size() == 0) m_state = 3;
      end
      default: begin exp_en = 0; exp_tag = "R8"; m_state = 0; end
    endcase
    if (m_cap_v) fq.push_back('{m_cap_n, !up_en, cyc + 1});
    m_cap_v = up_en && m_armed;
    m_cap_n = up_dat;
    if (!up_en) m_armed = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (pop_d && lq.size() > 0) void'(lq.pop_front());
    checks++;
    if (dn_en !== exp_en || (exp_en && dn_dat !== 4'(exp_dat))) begin
      errors++;
      $display("FAIL %s cycle %0d: actual en=%0b dat=%0h expected en=%0b dat=%0h",
               exp_tag, cyc, dn_en, dn_dat, exp_en, exp_dat);
    end
    if (dn_en) cur.push_back(dn_dat);
    else if (cur.size() > 0) begin
      rec_id.push_back((cur[0] << 2) | (cur[1] >> 2));
      rec_type.push_back((cur[1] >> 1) & 1);
      rec_len.push_back(cur[2]);
      cur.delete();
    end
    if (sq_en.size() > 0) begin
      up_en = 1'(sq_en.pop_front()); up_dat = 4'(sq_dat.pop_front());
    end else begin
      up_en = 1'b0; up_dat = '0;
    end
    loc_len  = 4'((lq.size() > 15) ? 15 : lq.size());
    loc_word = 16'((lq.size() > 0) ? lq[0] : 0);
    #1;
    pop_d = loc_pop;
    model_step();
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int count_id(int id);
    int c = 0;
    foreach (rec_id[i]) if (rec_id[i] == id) c++;
    return c;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int base;
    // R10: a packet already streaming when reset is released
    put_pkt(6'h15, 1, 2);
    rst = 1'b1;
    run(5);
    chk(dn_en == 1'b0, "R1 dn_en in reset", dn_en, 0);
    chk(loc_pop == 1'b0, "R1 loc_pop in reset", loc_pop, 0);
    rst = 1'b0;
    run(1);
    chk(dn_en == 1'b0, "R1 first edge after reset", dn_en, 0);
    run(20);
    chk(count_id(6'h15) == 0, "R10 fragment forwarded", count_id(6'h15), 0);

    // R2 / R9: master start packet and a non-predecessor packet
    put_pkt(6'h3F, 0, 0);
    put_pkt(0, 1, 2);
    run(40);
    chk(rec_id.size() == 2, "R2 forwarded packet count", rec_id.size(), 2);
    chk(count_id(NODE_ID) == 0, "R9 own packet without predecessor", count_id(NODE_ID), 0);

    // R4 / R6: predecessor packet, local words waiting
    lq.push_back(16'hbeef); lq.push_back(16'h1234);
    put_pkt(PRED, 1, 1);
    run(40);
    chk(rec_id[$] == NODE_ID, "R4 own packet follows predecessor", rec_id[$], NODE_ID);
    chk(rec_type[$] == 1 && rec_len[$] == 2, "R6 own data length", rec_len[$], 2);
    chk(lq.size() == 0, "R6 local words popped", lq.size(), 0);

    // R5: nothing to send
    put_pkt(PRED, 0, 0);
    run(30);
    chk(rec_id[$] == NODE_ID && rec_type[$] == 0, "R5 null type", rec_type[$], 0);
    chk(rec_len[$] == 0, "R5 null length", rec_len[$], 0);

    // R7: longest packet right behind the predecessor, 17 local words
    for (int w = 0; w < 17; w++) lq.push_back((w * 16'h1357 + 16'h0246) & 16'hffff);
    base = rec_id.size();
    put_pkt(PRED, 1, 0);
    put_pkt(3, 1, 15);
    run(220);
    chk(rec_id.size() == base + 3, "R7 packets out", rec_id.size(), base + 3);
    chk(rec_id[base] == PRED && rec_id[base+1] == NODE_ID && rec_id[base+2] == 3,
        "R7 order (own id at base+1)", rec_id[base+1], NODE_ID);
    chk(rec_len[base+1] == 15, "R6 saturated length", rec_len[base+1], 15);
    chk(lq.size() == 2, "R6 leftover local words", lq.size(), 2);

    // R6: words arriving after the turn starts wait for the next turn
    lq.delete();
    put_pkt(PRED, 1, 0);
    for (int i = 0; i < 100 && m_state != 2; i++) tick();
    for (int w = 0; w < 3; w++) lq.push_back(16'hc0de + w);
    run(40);
    chk(rec_id[$] == NODE_ID && rec_len[$] == 0, "R6 late words not sent", rec_len[$], 0);
    put_pkt(PRED, 1, 0);
    run(40);
    chk(rec_id[$] == NODE_ID && rec_len[$] == 3, "R6 late words next turn", rec_len[$], 3);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule